// File: doc/BRIEF.md
# Programmable Baud-Rate Divider

This block turns a free-running reference clock into a single-cycle enable pulse at sixteen times the serial bit rate. Transmit and receive sampling logic of a serial channel use this pulse. The division ratio is a 16-bit value that a CPU writes one byte at a time: one strobe stores the low byte and another stores the high byte. Both bytes can be read back on dedicated outputs.

The ratio is the reference frequency divided by sixteen times the wanted bit rate. Any write to either byte restarts the count from the new ratio at once. A freshly programmed rate therefore never waits out the remainder of an old, possibly very long, count. A ratio of zero stops the pulse, and a ratio of one produces it on every cycle.

Top module: `baud_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both stored bytes read as zero and the tick is low. No tick appears until a nonzero ratio is written.
- R2: A cycle with `lo_wr` high stores `wr_data` as the low byte (ratio bits 7:0). It reads back unchanged on `lo_rd` from the next cycle, and the high byte is not altered.
- R3: A cycle with `hi_wr` high stores `wr_data` as the high byte (ratio bits 15:8), and it reads back on `hi_rd` from the next cycle. When both strobes are high in the same cycle, both bytes take `wr_data`.
- R4: In a cycle with neither strobe high, both stored bytes keep their values.
- R5: After a write that leaves a ratio N of 1 or more, the first tick is high in the N-th cycle after the write edge. The cycle right after the write therefore ticks only when N is 1.
- R6: With a ratio N of 2 or more and no further writes, the tick is high for exactly one cycle in every N, and consecutive ticks are N cycles apart.
- R7: With a ratio of 1, the tick is high in every cycle.
- R8: With a ratio of 0, the tick stays low.
- R9: A write in the middle of a count drops the remainder of the old count. Timing follows R5 from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_wr | input | 1 | Store strobe for the low ratio byte |
| hi_wr | input | 1 | Store strobe for the high ratio byte |
| wr_data | input | 8 | Byte written by either strobe |
| lo_rd | output | 8 | Stored low ratio byte |
| hi_rd | output | 8 | Stored high ratio byte |
| tick16 | output | 1 | One-cycle enable at sixteen times the bit rate |

## Verification
Directed ratios of 0, 1, 5, 256 and 65535 each test one case. A ratio of 0 shows whether the tick is really stopped. A ratio of 1 tests the every-cycle case against the count-down end condition, and 5 and 256 confirm the period for a low-only ratio and a high-only ratio. A rewrite partway through a count of 7 shows whether the counter restarts or finishes its old run. Random writes to one byte, the other byte or both bytes, separated by random idle gaps, run against a bench model that tracks cycles since the last write. This model catches off-by-one reload errors and byte-lane mix-ups.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned LANES      = 2;

    // index of each byte lane inside the ratio word
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // true when a count register sits on its terminal value
    function automatic logic at_terminal(input logic [2*BYTE_W_DEF-1:0] cnt);
        return cnt == {{(2*BYTE_W_DEF-1){1'b0}}, 1'b1};
    endfunction

    // true when the count must restart from the stored ratio
    function automatic logic must_reload(input logic [2*BYTE_W_DEF-1:0] cnt);
        return cnt <= {{(2*BYTE_W_DEF-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/baud_ratio_bank.sv
module baud_ratio_bank
    import baud_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_W_DEF,
    localparam int unsigned RATIO_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] ratio_next,
    output logic              any_wr
);

    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][BYTE_W-1:0] lane_q;
    logic [LANES-1:0][BYTE_W-1:0] lane_nx;

    assign lane_we[LANE_LO] = lo_wr;
    assign lane_we[LANE_HI] = hi_wr;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[gi] <= '0;
            end else if (lane_we[gi]) begin
                lane_q[gi] <= wr_data;
            end
        end
        assign lane_nx[gi] = lane_we[gi] ? wr_data : lane_q[gi];
    end

    assign ratio_q    = lane_q;
    assign ratio_next = lane_nx;
    assign any_wr     = |lane_we;

endmodule

// File: rtl/baud_downcount.sv
module baud_downcount
    import baud_pkg::*;
#(
    parameter int unsigned CNT_W = 2 * BYTE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             terminal;
    logic             wrap;

    assign terminal = (cnt_q == CNT_W'(1));
    assign wrap     = (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (wrap) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign tick = terminal;

endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo_rd,
    output logic [BYTE_W-1:0] hi_rd,
    output logic              tick16
);

    localparam int unsigned RATIO_W = BYTE_W * LANES;

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] ratio_next;
    logic               any_wr;

    baud_ratio_bank #(.BYTE_W(BYTE_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .lo_wr      (lo_wr),
        .hi_wr      (hi_wr),
        .wr_data    (wr_data),
        .ratio_q    (ratio_q),
        .ratio_next (ratio_next),
        .any_wr     (any_wr)
    );

    baud_downcount #(.CNT_W(RATIO_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (any_wr),
        .load_val   (ratio_next),
        .reload_val (ratio_q),
        .tick       (tick16)
    );

    assign lo_rd = ratio_q[BYTE_W-1:0];
    assign hi_rd = ratio_q[RATIO_W-1:BYTE_W];

endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lo_wr,
    input logic              hi_wr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] lo_rd,
    input logic [BYTE_W-1:0] hi_rd,
    input logic              tick16
);

    logic [2*BYTE_W-1:0] ratio;
    assign ratio = {hi_rd, lo_rd};

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ratio == '0 && !tick16)); // R1

    AST_LO_STORE: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && !hi_wr) |=> (lo_rd == $past(wr_data) && $stable(hi_rd))); // R2

    AST_HI_STORE: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (hi_rd == $past(wr_data))); // R3

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!lo_wr && !hi_wr) |=> $stable(ratio)); // R4

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (lo_wr || hi_wr) |=> (tick16 == (ratio == 1))); // R5

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick16 && ratio > 1 && !lo_wr && !hi_wr) |=> !tick16); // R6

    AST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (ratio == 1) |-> tick16); // R7

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ratio == '0) |-> !tick16); // R8

endmodule

bind baud_divider baud_divider_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .wr_data (wr_data),
    .lo_rd   (lo_rd),
    .hi_rd   (hi_rd),
    .tick16  (tick16)
);

// File: tb/tb_baud_divider.sv
`timescale 1ns/1ps
module tb_baud_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lo_wr = 1'b0;
    logic       hi_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] lo_rd;
    logic [7:0] hi_rd;
    logic       tick16;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done = 0;

    // reference state
    logic [7:0] m_lo = '0;
    logic [7:0] m_hi = '0;
    int unsigned m_k = 0;      // cycles since the last write edge (0 = first)
    string       tag_ovr = "";
    string       latch_tag = "R4";

    baud_divider dut (
        .clk(clk), .rst(rst), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .wr_data(wr_data), .lo_rd(lo_rd), .hi_rd(hi_rd), .tick16(tick16)
    );

    always #10 clk = ~clk;

    function automatic logic exp_tick(input logic [15:0] n, input int unsigned k);
        if (n == 0) return 1'b0;
        return (k % n) == (n - 1);
    endfunction

    function automatic string tick_tag(input logic [15:0] n, input int unsigned k);
        if (tag_ovr != "") return tag_ovr;
        if (n == 0) return "R8";
        if (n == 1) return "R7";
        if (k < n) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] n;
        n = {m_hi, m_lo};
        check(latch_tag, "lo_rd", {8'h0, lo_rd}, {8'h0, m_lo});
        check(latch_tag == "R2" ? "R4" : latch_tag, "hi_rd", {8'h0, hi_rd}, {8'h0, m_hi});
        check(tick_tag(n, m_k), "tick16", {15'h0, tick16}, {15'h0, exp_tick(n, m_k)});
    endtask

    // called at a negedge; applies inputs over one rising edge
    task automatic step(input logic wl, input logic wh, input logic [7:0] d);
        lo_wr = wl; hi_wr = wh; wr_data = d;
        @(posedge clk);
        if (wl) m_lo = d;
        if (wh) m_hi = d;
        if (wl || wh) m_k = 0; else m_k++;
        if (wl && wh) latch_tag = "R3";
        else if (wh) latch_tag = "R3";
        else if (wl) latch_tag = "R2";
        else latch_tag = "R4";
        @(negedge clk);
        lo_wr = 1'b0; hi_wr = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int unsigned n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values while reset is held
        check("R1", "lo_rd in reset", {8'h0, lo_rd}, 16'h0);
        check("R1", "hi_rd in reset", {8'h0, hi_rd}, 16'h0);
        check("R1", "tick16 in reset", {15'h0, tick16}, 16'h0);
        rst = 1'b0;
        tag_ovr = "R1";
        idle(12);                 // R1: no tick without a ratio
        tag_ovr = "";

        step(1'b1, 1'b0, 8'd5);   // R2, R5: low byte only
        idle(20);                 // R6
        step(1'b1, 1'b0, 8'd1);   // R7
        idle(6);
        step(1'b1, 1'b0, 8'd0);   // R8
        idle(10);
        step(1'b1, 1'b1, 8'h01);  // R3: both lanes, ratio 0x0101
        step(1'b1, 1'b0, 8'h00);  // ratio 0x0100 = 256
        idle(600);                // R6 with high byte only
        step(1'b1, 1'b0, 8'd7);
        idle(3);
        tag_ovr = "R9";           // R9: rewrite mid count
        step(1'b1, 1'b0, 8'd3);
        idle(10);
        tag_ovr = "";
        step(1'b1, 1'b1, 8'hFF);  // ratio 65535, no early tick
        idle(40);
        step(1'b0, 1'b1, 8'h00);  // back to 0x00FF
        idle(300);

        for (int it = 0; it < 60; it++) begin
            logic [1:0] sel;
            logic [7:0] d;
            sel = 2'($urandom_range(3, 1));
            if (sel == 2'b10 || sel == 2'b11)
                d = ($urandom_range(3, 0) == 0) ? 8'($urandom_range(2, 0)) : 8'h00;
            else
                d = 8'($urandom_range(12, 0));
            if (sel == 2'b11) d = 8'($urandom_range(2, 0));
            step(sel[0], sel[1], d);
            idle($urandom_range(40, 0));
        end

        finish_run();
    end

endmodule